// File: doc/BRIEF.md
# Write-Through Store Queue with Load Forwarding

This block sits between a write-through cache controller and lower-level memory. It takes stores from the processor side as word address and data pairs and holds them in a small circular queue. The processor therefore does not wait for each word to reach memory. Queued stores go out strictly oldest first, one at a time, over a request/acknowledge memory port. Every accepted store is written. Two stores to the same word are written as two separate memory writes; they are never merged.

Loads must never see stale memory, and the block offers two ways to avoid that. A combinational lookup port compares a load address against every pending entry. On a match it returns the data of the youngest matching store. A controller can instead wait for the empty flag and read memory only once the queue has drained.

When every slot is occupied, the block raises a stall. A store presented during a stall is not taken, and the source must present it again later.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset, `empty_o` is 1, `occupancy_o` is 0, `mem_req_o` is 0, `st_stall_o` is 0 and `ld_hit_o` is 0.
- R2: Each accepted store produces exactly one memory write (a cycle with `mem_req_o` and `mem_ack_i` both high) carrying its address and data. Writes leave in acceptance order, and repeated stores to one address are all written.
- R3: With the memory port not acknowledging, DEPTH (default 4) stores on consecutive cycles are all accepted without `st_stall_o` rising before the last one is taken.
- R4: `st_stall_o` is 1 exactly when DEPTH entries are pending. A store presented while it is 1 is dropped: occupancy is unchanged, and the dropped address is not found by the lookup port.
- R5: Once `mem_req_o` is 1, it stays 1 with `mem_addr_o` and `mem_data_o` unchanged until a cycle in which `mem_ack_i` is 1. The head entry is removed at the clock edge of that cycle.
- R6: `ld_hit_o` is 1 and `ld_data_o` equals the stored data when `ld_addr_i` matches a pending entry. `ld_hit_o` is 0 when no pending entry matches.
- R7: When several pending entries match `ld_addr_i`, `ld_data_o` is the data of the most recently accepted one.
- R8: A store accepted in the same cycle as a memory acknowledge is kept, the head is removed, and `occupancy_o` is unchanged across that edge.
- R9: `empty_o` is 1 exactly when no entry is pending. An entry that has been written to memory is no longer reported by the lookup port.
- R10: An accepted store is visible on the lookup port and counted in `occupancy_o` from the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request from the processor side |
| st_addr_i | input | AW (32) | Store word address |
| st_data_i | input | DW (32) | Store data |
| st_stall_o | output | 1 | Queue full; the store in this cycle is not taken |
| ld_addr_i | input | AW (32) | Load lookup address |
| ld_hit_o | output | 1 | A pending store matches the lookup address |
| ld_data_o | output | DW (32) | Data of the youngest matching pending store |
| mem_req_o | output | 1 | Write request to lower-level memory |
| mem_addr_o | output | AW (32) | Address of the head entry |
| mem_data_o | output | DW (32) | Data of the head entry |
| mem_ack_i | input | 1 | Memory accepts the current write |
| empty_o | output | 1 | No store is pending |
| occupancy_o | output | $clog2(DEPTH)+1 (3) | Number of pending entries |

## Verification
The bench provokes two collisions: a store being taken in the same cycle that memory acknowledges the head, and a lookup racing the draining entries. In the first case, the bench lets the responder acknowledge at the same edge a store is accepted. It then judges the result by the unchanged occupancy, by the old head address no longer being found and the new store being found, and by the scoreboard receiving both writes in order. A long stretch with a slow, gapped acknowledge and stores over a four-address set keeps both events coinciding many times, while a monitor compares every memory write against the queue of expected stores and checks that the request holds steady while it is waiting.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
   localparam int unsigned SDB_AW_DEF    = 32;
   localparam int unsigned SDB_DW_DEF    = 32;
   localparam int unsigned SDB_DEPTH_DEF = 4;

   function automatic bit sdb_is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/sdb_store.sv
module sdb_store
   import sdb_pkg::*;
#(
   parameter int unsigned AW    = SDB_AW_DEF,
   parameter int unsigned DW    = SDB_DW_DEF,
   parameter int unsigned DEPTH = SDB_DEPTH_DEF,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = PW + 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                push_i,
   input  logic [AW-1:0]       push_addr_i,
   input  logic [DW-1:0]       push_data_i,
   input  logic                pop_i,
   output logic [AW-1:0]       head_addr_o,
   output logic [DW-1:0]       head_data_o,
   output logic [PW-1:0]       rd_ptr_o,
   output logic [CW-1:0]       count_o,
   output logic [DEPTH*AW-1:0] addr_flat_o,
   output logic [DEPTH*DW-1:0] data_flat_o
);
   if (!sdb_is_pow2(DEPTH)) begin : g_bad_depth
      $error("sdb_store: DEPTH must be a power of two, at least 2");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] wr_ptr_q, rd_ptr_q;
   logic [CW-1:0] count_q;

   always_ff @(posedge clk_i) begin
      if (push_i) begin
         addr_q[wr_ptr_q] <= push_addr_i;
         data_q[wr_ptr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
         case ({push_i, pop_i})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign addr_flat_o[g*AW +: AW] = addr_q[g];
      assign data_flat_o[g*DW +: DW] = data_q[g];
   end

   assign head_addr_o = addr_q[rd_ptr_q];
   assign head_data_o = data_q[rd_ptr_q];
   assign rd_ptr_o    = rd_ptr_q;
   assign count_o     = count_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= CW'(DEPTH)); // R4
   AST_PUSH_POP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i) |=> $stable(count_q)); // R8
   AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i) |=> (count_q != '0)); // R10
endmodule

// File: rtl/sdb_match.sv
module sdb_match
   import sdb_pkg::*;
#(
   parameter int unsigned AW    = SDB_AW_DEF,
   parameter int unsigned DW    = SDB_DW_DEF,
   parameter int unsigned DEPTH = SDB_DEPTH_DEF,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = PW + 1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [AW-1:0]       ld_addr_i,
   input  logic [PW-1:0]       rd_ptr_i,
   input  logic [CW-1:0]       count_i,
   input  logic [DEPTH*AW-1:0] addr_flat_i,
   input  logic [DEPTH*DW-1:0] data_flat_i,
   output logic                hit_o,
   output logic [DW-1:0]       data_o
);
   logic [DEPTH-1:0] eq;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = (addr_flat_i[g*AW +: AW] == ld_addr_i);
   end

   // walk from oldest to youngest; a later match overrides an earlier one
   always_comb begin
      logic [PW-1:0] slot;
      hit_o  = 1'b0;
      data_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = rd_ptr_i + PW'(k);
         if ((CW'(k) < count_i) && eq[slot]) begin
            hit_o  = 1'b1;
            data_o = data_flat_i[slot*DW +: DW];
         end
      end
   end

   AST_EMPTY_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_i == '0) |-> !hit_o); // R9
endmodule

// File: rtl/sdb_drain.sv
module sdb_drain
   import sdb_pkg::*;
#(
   parameter int unsigned AW    = SDB_AW_DEF,
   parameter int unsigned DW    = SDB_DW_DEF,
   parameter int unsigned DEPTH = SDB_DEPTH_DEF,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] count_i,
   input  logic [AW-1:0] head_addr_i,
   input  logic [DW-1:0] head_data_i,
   input  logic          mem_ack_i,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_data_o,
   output logic          pop_o
);
   assign mem_req_o  = (count_i != '0);
   assign mem_addr_o = head_addr_i;
   assign mem_data_o = head_data_i;
   assign pop_o      = mem_req_o && mem_ack_i;

   AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> mem_req_o); // R5
   AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_data_o))); // R5
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
   import sdb_pkg::*;
#(
   parameter int unsigned AW    = SDB_AW_DEF,
   parameter int unsigned DW    = SDB_DW_DEF,
   parameter int unsigned DEPTH = SDB_DEPTH_DEF,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = PW + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          st_valid_i,
   input  logic [AW-1:0] st_addr_i,
   input  logic [DW-1:0] st_data_i,
   output logic          st_stall_o,
   input  logic [AW-1:0] ld_addr_i,
   output logic          ld_hit_o,
   output logic [DW-1:0] ld_data_o,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_data_o,
   input  logic          mem_ack_i,
   output logic          empty_o,
   output logic [CW-1:0] occupancy_o
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("store_drain_buffer: AW and DW must be positive");
   end

   logic                push, pop, full;
   logic [AW-1:0]       head_addr;
   logic [DW-1:0]       head_data;
   logic [PW-1:0]       rd_ptr;
   logic [CW-1:0]       count;
   logic [DEPTH*AW-1:0] addr_flat;
   logic [DEPTH*DW-1:0] data_flat;

   assign full = (count == CW'(DEPTH));
   assign push = st_valid_i && !full;

   sdb_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push),
      .push_addr_i (st_addr_i),
      .push_data_i (st_data_i),
      .pop_i       (pop),
      .head_addr_o (head_addr),
      .head_data_o (head_data),
      .rd_ptr_o    (rd_ptr),
      .count_o     (count),
      .addr_flat_o (addr_flat),
      .data_flat_o (data_flat)
   );

   sdb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ld_addr_i   (ld_addr_i),
      .rd_ptr_i    (rd_ptr),
      .count_i     (count),
      .addr_flat_i (addr_flat),
      .data_flat_i (data_flat),
      .hit_o       (ld_hit_o),
      .data_o      (ld_data_o)
   );

   sdb_drain #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_drain (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .count_i     (count),
      .head_addr_i (head_addr),
      .head_data_i (head_data),
      .mem_ack_i   (mem_ack_i),
      .mem_req_o   (mem_req_o),
      .mem_addr_o  (mem_addr_o),
      .mem_data_o  (mem_data_o),
      .pop_o       (pop)
   );

   assign st_stall_o  = full;
   assign empty_o     = (count == '0);
   assign occupancy_o = count;

   AST_STALL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_stall_o && !mem_ack_i) |=> $stable(occupancy_o)); // R4
   AST_EMPTY_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o |-> (!mem_req_o && !st_stall_o)); // R9
endmodule

// File: tb/store_drain_buffer_tb_top.sv
module store_drain_buffer_tb_top;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int CW = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_stall;
   logic [AW-1:0] ld_addr = '0;
   logic          ld_hit;
   logic [DW-1:0] ld_data;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic          mem_ack = 1'b0;
   logic          empty;
   logic [CW-1:0] occ;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   store_drain_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_stall_o(st_stall),
      .ld_addr_i(ld_addr), .ld_hit_o(ld_hit), .ld_data_o(ld_data),
      .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack),
      .empty_o(empty), .occupancy_o(occ)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard of expected memory writes {addr,data}
   logic [AW+DW-1:0] exp_q[$];
   bit               ack_en = 1'b0;
   int               ack_gap = 0;
   int               gap_cnt = 0;
   bit               held_v = 1'b0;
   logic [AW-1:0]    held_a;
   logic [DW-1:0]    held_d;

   // memory responder + monitor
   always @(negedge clk) begin
      #1;
      if (!rst_n) begin
         mem_ack = 1'b0; held_v = 1'b0; gap_cnt = 0;
      end else begin
         if (held_v) begin
            chk(mem_req, "R5 request dropped before ack", 64'(mem_req), 64'd1);
            chk(mem_addr == held_a && mem_data == held_d, "R5 head changed before ack",
                {mem_addr, mem_data}, {held_a, held_d});
         end
         mem_ack = ack_en && mem_req && (gap_cnt >= ack_gap);
         if (mem_req && mem_ack) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected memory write", {mem_addr, mem_data}, 64'd0);
            end else begin
               logic [AW+DW-1:0] e;
               e = exp_q.pop_front();
               chk({mem_addr, mem_data} == e, "R2 memory write order/content", {mem_addr, mem_data}, e);
            end
            gap_cnt = 0;
         end else if (mem_req) begin
            gap_cnt++;
         end
         held_v = mem_req && !mem_ack;
         held_a = mem_addr;
         held_d = mem_data;
      end
   end

   // driver: called at a falling edge; returns at the falling edge after acceptance
   task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      st_valid = 1'b1; st_addr = a; st_data = d;
      while (st_stall) @(negedge clk);
      exp_q.push_back({a, d});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      st_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic lookup(input logic [AW-1:0] a, input bit exp_hit, input logic [DW-1:0] exp_d, input string tag);
      ld_addr = a;
      #2;
      chk(ld_hit == exp_hit, {tag, " hit"}, 64'(ld_hit), 64'(exp_hit));
      if (exp_hit) chk(ld_data == exp_d, {tag, " data"}, 64'(ld_data), 64'(exp_d));
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 2000 && !empty; i++) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      logic [CW-1:0] occ_before;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(empty == 1'b1, "R1 empty", 64'(empty), 64'd1);
      chk(occ == '0, "R1 occupancy", 64'(occ), 64'd0);
      chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
      chk(st_stall == 1'b0, "R1 stall", 64'(st_stall), 64'd0);
      lookup(32'h10, 1'b0, '0, "R1 lookup");
      rst_n = 1'b1;
      @(negedge clk);

      // R10 / R6: single store visible after its edge, memory held off
      ack_en = 1'b0;
      store(32'h10, 32'hA1);
      chk(occ == 1, "R10 occupancy after one store", 64'(occ), 64'd1);
      chk(!empty, "R9 not empty", 64'(empty), 64'd0);
      lookup(32'h10, 1'b1, 32'hA1, "R6 single hit");
      lookup(32'h99, 1'b0, '0, "R6 miss");

      // R3: three more back to back without stall before the last is taken
      chk(!st_stall, "R3 no stall at 1", 64'(st_stall), 64'd0);
      store(32'h20, 32'hB2);
      chk(!st_stall, "R3 no stall at 2", 64'(st_stall), 64'd0);
      store(32'h10, 32'hA3);
      chk(!st_stall, "R3 no stall at 3", 64'(st_stall), 64'd0);
      store(32'h30, 32'hC4);
      st_valid = 1'b0;
      chk(occ == 4, "R3 occupancy full", 64'(occ), 64'd4);
      chk(st_stall, "R4 stall when full", 64'(st_stall), 64'd1);

      // R7 youngest match wins
      lookup(32'h10, 1'b1, 32'hA3, "R7 youngest");
      lookup(32'h30, 1'b1, 32'hC4, "R6 tail entry");

      // R4 store during stall is dropped
      st_valid = 1'b1; st_addr = 32'h55; st_data = 32'hD5;
      @(negedge clk);
      st_valid = 1'b0;
      @(negedge clk);
      chk(occ == 4, "R4 occupancy unchanged", 64'(occ), 64'd4);
      lookup(32'h55, 1'b0, '0, "R4 dropped store");

      // R2 / R5: drain with a slow acknowledge
      ack_gap = 2; ack_en = 1'b1;
      wait_empty();
      chk(empty, "R9 drained", 64'(empty), 64'd1);
      lookup(32'h10, 1'b0, '0, "R9 drained entry gone");
      chk(exp_q.size() == 0, "R2 all written", 64'(exp_q.size()), 64'd0);

      // R8 simultaneous store and acknowledge
      ack_en = 1'b0;
      @(negedge clk);
      store(32'h40, 32'hE1);
      st_valid = 1'b0;
      @(negedge clk);
      occ_before = occ;
      ack_gap = 0; ack_en = 1'b1;
      store(32'h44, 32'hE2);
      ack_en = 1'b0;
      st_valid = 1'b0;
      chk(occ == occ_before, "R8 occupancy unchanged", 64'(occ), 64'(occ_before));
      lookup(32'h40, 1'b0, '0, "R8 old head removed");
      lookup(32'h44, 1'b1, 32'hE2, "R8 new store kept");
      ack_en = 1'b1;
      wait_empty();
      chk(exp_q.size() == 0, "R8 both written", 64'(exp_q.size()), 64'd0);

      // stress: small address set, gapped acknowledge, repeated addresses
      lfsr = 8'h5B;
      for (int i = 0; i < 60; i++) begin
         ack_gap = i % 3;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         store(32'h100 + 32'(lfsr[1:0]), 32'h1000 + 32'(i));
         if (lfsr[6]) idle(1);
      end
      st_valid = 1'b0;
      wait_empty();
      chk(empty, "R9 empty after stress", 64'(empty), 64'd1);
      chk(exp_q.size() == 0, "R2 stress all written", 64'(exp_q.size()), 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule